// File: doc/BRIEF.md
# Dual-Bus Command Snoop Striper

This block sits between a transmit byte source and two parallel serial-flash buses that together hold one logical memory. It reads the first byte of every transaction as a flash opcode and decides, byte by byte, whether the next outgoing byte is copied onto both buses or whether consecutive bytes are dealt out alternately to bus 0 and bus 1. Command, address, mode and dummy bytes must reach both devices, while read data is split between them, so each device holds alternate bytes of the stream.

A drain is started with a one-cycle `flush_start` pulse. From then on the block performs one byte transfer per clock cycle, pulling bytes from the source, sending them to the buses and pushing the returned bytes into the receive sink. The drain ends when the source is empty at the moment a byte is needed. The snoop state survives between drains and is returned to opcode-checking whenever the chip-select-idle input is high. The snoop state is held in 8 bits: 0xFF means checking for an opcode, 0xFE means no striping, 0x00 means striping, and any other value is the number of copied bytes still to go.

Top module: `snoop_stripe_top`

## Requirements
- R1: While `cs_idle` is high the snoop state returns to opcode-checking, so the first byte after it is decoded as a new opcode, even if striping was active before.
- R2: In the checking state, opcode 0x0B, 0x6B or 0xBB causes the 4 bytes following it to be copied to both buses; the byte after those is the first striped byte.
- R3: In the checking state, opcode 0xEB causes the 6 bytes following it to be copied to both buses before striping starts.
- R4: Any other opcode in the checking state disables striping: every later byte is copied to both buses until `cs_idle` is raised.
- R5: Outside striping, with both buses in use, one source byte goes to both buses in the same cycle and only bus 0's returned byte is pushed to the sink.
- R6: While striping, bytes go alternately to bus 0 and then bus 1, one bus per cycle, and each bus's returned byte is pushed in that same order.
- R7: When a byte is needed and `tx_valid` is low, `underflow` pulses for one cycle, no bus transfer takes place, the drain stops (`busy` falls) and the next drain starts again with bus 0.
- R8: When `rx_full` is high during a transfer, the bus transfer still happens, the returned byte is not pushed and `overflow` pulses in that cycle.
- R9: Two buses are used only when `two_mem` and `sep_bus` are both high; otherwise bus 1 never transfers and all bytes go to bus 0 with their returned bytes kept.
- R10: The striping state persists across drains: a new drain without `cs_idle` continues striping from its first byte.
- R11: After reset the block is idle (`busy` low, no transfers) and in the checking state (`striping` low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_start | input | 1 | One-cycle request to begin draining the source |
| cs_idle | input | 1 | High when no chip select is active; forces opcode-checking |
| two_mem | input | 1 | Two memory devices are fitted |
| sep_bus | input | 1 | The two devices sit on separate buses |
| tx_valid | input | 1 | Source holds at least one byte |
| tx_data | input | DATA_W | Head byte of the source |
| tx_pop | output | 1 | Consume the head byte of the source this cycle |
| rx_full | input | 1 | Receive sink cannot accept a byte |
| rx_push | output | 1 | Write `rx_data` into the sink this cycle |
| rx_data | output | DATA_W | Returned byte for the sink |
| b0_xfer | output | 1 | Bus 0 performs a byte transfer this cycle |
| b0_tx | output | DATA_W | Byte sent on bus 0 |
| b0_rx | input | DATA_W | Byte returned by bus 0 in the same cycle |
| b1_xfer | output | 1 | Bus 1 performs a byte transfer this cycle |
| b1_tx | output | DATA_W | Byte sent on bus 1 |
| b1_rx | input | DATA_W | Byte returned by bus 1 in the same cycle |
| busy | output | 1 | A drain is in progress |
| striping | output | 1 | Snoop state is striping |
| underflow | output | 1 | One-cycle pulse: source empty when a byte was needed |
| overflow | output | 1 | One-cycle pulse: returned byte dropped because the sink was full |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a short countdown of 4 and a long countdown of 6. With these values every opcode class reaches striping within a dozen source bytes, so the full walk from opcode through the copied bytes into alternating data, an odd-length stripe that ends between bus 0 and bus 1, and a striping state carried into a following drain all fit in short directed streams. Bus devices are modelled as fixed byte transforms that differ per bus, which makes it visible which bus produced each byte in the sink.

// File: rtl/snoop_stripe_pkg.sv
package snoop_stripe_pkg;

    // 8-bit snoop state; any value outside the three codes is a countdown
    typedef logic [7:0] snoop_t;

    localparam snoop_t SNP_CHECK  = 8'hFF;
    localparam snoop_t SNP_NONE   = 8'hFE;
    localparam snoop_t SNP_STRIPE = 8'h00;

    typedef struct packed {
        logic busy;
        logic lane;   // 0: bus 0 owes the next striped byte, 1: bus 1
    } eng_t;

endpackage

// File: rtl/snoop_opcode_dec.sv
module snoop_opcode_dec
    import snoop_stripe_pkg::*;
#(
    parameter int           W         = 8,
    parameter int           SHORT_CNT = 4,
    parameter int           LONG_CNT  = 6,
    parameter logic [W-1:0] OP_FAST   = 8'h0B,
    parameter logic [W-1:0] OP_QOUT   = 8'h6B,
    parameter logic [W-1:0] OP_DIO    = 8'hBB,
    parameter logic [W-1:0] OP_QIO    = 8'hEB
) (
    input  logic [W-1:0] opcode,
    output snoop_t       load_val
);

    localparam snoop_t SHORT_V = snoop_t'(SHORT_CNT);
    localparam snoop_t LONG_V  = snoop_t'(LONG_CNT);

    always_comb begin
        if (opcode == OP_QIO) begin
            load_val = LONG_V;
        end else if (opcode == OP_FAST || opcode == OP_QOUT || opcode == OP_DIO) begin
            load_val = SHORT_V;
        end else begin
            load_val = SNP_NONE;
        end
    end

endmodule

// File: rtl/snoop_tracker.sv
module snoop_tracker
    import snoop_stripe_pkg::*;
#(
    parameter int W         = 8,
    parameter int SHORT_CNT = 4,
    parameter int LONG_CNT  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_idle,
    input  logic         beat_done,
    input  logic [W-1:0] opcode,
    output snoop_t       state_q
);

    snoop_t load_val;
    snoop_t state_d;

    snoop_opcode_dec #(
        .W        (W),
        .SHORT_CNT(SHORT_CNT),
        .LONG_CNT (LONG_CNT)
    ) u_dec (
        .opcode  (opcode),
        .load_val(load_val)
    );

    always_comb begin
        state_d = state_q;
        if (cs_idle) begin
            state_d = SNP_CHECK;
        end else if (beat_done) begin
            unique case (state_q)
                SNP_CHECK:            state_d = load_val;
                SNP_STRIPE, SNP_NONE: state_d = state_q;
                default:              state_d = state_q - 8'd1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SNP_CHECK;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/lane_router.sv
module lane_router #(
    parameter int W = 8
) (
    input  logic         run,
    input  logic         lane,
    input  logic         stripe_st,
    input  logic         dual,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_data,
    input  logic [W-1:0] b0_rx,
    input  logic [W-1:0] b1_rx,
    input  logic         rx_full,
    output logic         tx_pop,
    output logic         b0_xfer,
    output logic         b1_xfer,
    output logic [W-1:0] b0_tx,
    output logic [W-1:0] b1_tx,
    output logic         rx_push,
    output logic [W-1:0] rx_data,
    output logic         underflow,
    output logic         overflow,
    output logic         beat_done,
    output logic         lane_next
);

    logic split;

    always_comb begin
        split     = stripe_st & dual;
        tx_pop    = 1'b0;
        b0_xfer   = 1'b0;
        b1_xfer   = 1'b0;
        b0_tx     = tx_data;
        b1_tx     = tx_data;
        rx_push   = 1'b0;
        rx_data   = b0_rx;
        underflow = 1'b0;
        overflow  = 1'b0;
        beat_done = 1'b0;
        lane_next = lane;
        if (run) begin
            if (!tx_valid) begin
                underflow = 1'b1;
                lane_next = 1'b0;
            end else begin
                tx_pop   = 1'b1;
                rx_push  = ~rx_full;
                overflow = rx_full;
                if (!split) begin
                    b0_xfer   = 1'b1;
                    b1_xfer   = dual;
                    beat_done = 1'b1;
                    lane_next = 1'b0;
                end else if (!lane) begin
                    b0_xfer   = 1'b1;
                    lane_next = 1'b1;
                end else begin
                    b1_xfer   = 1'b1;
                    rx_data   = b1_rx;
                    beat_done = 1'b1;
                    lane_next = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/snoop_stripe_top.sv
module snoop_stripe_top
    import snoop_stripe_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SHORT_CNT = 4,
    parameter int LONG_CNT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_start,
    input  logic              cs_idle,
    input  logic              two_mem,
    input  logic              sep_bus,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              b0_xfer,
    output logic [DATA_W-1:0] b0_tx,
    input  logic [DATA_W-1:0] b0_rx,
    output logic              b1_xfer,
    output logic [DATA_W-1:0] b1_tx,
    input  logic [DATA_W-1:0] b1_rx,
    output logic              busy,
    output logic              striping,
    output logic              underflow,
    output logic              overflow
);

    eng_t   eng_d, eng_q;
    snoop_t state_q;
    logic   dual;
    logic   beat_done;
    logic   lane_next;

    assign dual     = two_mem & sep_bus;
    assign busy     = eng_q.busy;
    assign striping = (state_q == SNP_STRIPE);

    snoop_tracker #(
        .W        (DATA_W),
        .SHORT_CNT(SHORT_CNT),
        .LONG_CNT (LONG_CNT)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_idle  (cs_idle),
        .beat_done(beat_done),
        .opcode   (tx_data),
        .state_q  (state_q)
    );

    lane_router #(
        .W(DATA_W)
    ) u_route (
        .run      (eng_q.busy),
        .lane     (eng_q.lane),
        .stripe_st(striping),
        .dual     (dual),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .b0_rx    (b0_rx),
        .b1_rx    (b1_rx),
        .rx_full  (rx_full),
        .tx_pop   (tx_pop),
        .b0_xfer  (b0_xfer),
        .b1_xfer  (b1_xfer),
        .b0_tx    (b0_tx),
        .b1_tx    (b1_tx),
        .rx_push  (rx_push),
        .rx_data  (rx_data),
        .underflow(underflow),
        .overflow (overflow),
        .beat_done(beat_done),
        .lane_next(lane_next)
    );

    always_comb begin
        eng_d = eng_q;
        if (!eng_q.busy) begin
            if (flush_start) begin
                eng_d.busy = 1'b1;
                eng_d.lane = 1'b0;
            end
        end else begin
            eng_d.lane = lane_next;
            if (underflow) begin
                eng_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

endmodule

// File: rtl/snoop_stripe_chk.sv
module snoop_stripe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_idle,
    input logic       two_mem,
    input logic       sep_bus,
    input logic [7:0] tx_data,
    input logic       tx_pop,
    input logic       rx_full,
    input logic       rx_push,
    input logic       b0_xfer,
    input logic       b1_xfer,
    input logic       busy,
    input logic       striping,
    input logic       underflow,
    input logic [7:0] state_q,
    input logic       beat_done
);

    logic counting;
    assign counting = (state_q != 8'hFF) && (state_q != 8'hFE) && (state_q != 8'h00);

    p_check_after_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (state_q == 8'hFF));

    p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && beat_done && !cs_idle) |=> (state_q == $past(state_q) - 8'd1));

    p_long_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 8'hFF && beat_done && !cs_idle && tx_data == 8'hEB) |=> (state_q == 8'd6));

    p_copy_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!striping && two_mem && sep_bus && b0_xfer) |-> b1_xfer);

    p_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (striping && two_mem && sep_bus && (b0_xfer || b1_xfer)) |-> (b0_xfer != b1_xfer));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(tx_pop || b0_xfer || b1_xfer));

    p_underflow_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !busy);

    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_push);

    p_single_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(two_mem && sep_bus) |-> !b1_xfer);

endmodule

bind snoop_stripe_top snoop_stripe_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_idle  (cs_idle),
    .two_mem  (two_mem),
    .sep_bus  (sep_bus),
    .tx_data  (tx_data[7:0]),
    .tx_pop   (tx_pop),
    .rx_full  (rx_full),
    .rx_push  (rx_push),
    .b0_xfer  (b0_xfer),
    .b1_xfer  (b1_xfer),
    .busy     (busy),
    .striping (striping),
    .underflow(underflow),
    .state_q  (state_q),
    .beat_done(beat_done)
);

// File: tb/sim_snoop_stripe_top.sv
module sim_snoop_stripe_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_start = 1'b0;
    logic       cs_idle = 1'b0;
    logic       two_mem = 1'b1;
    logic       sep_bus = 1'b1;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_pop;
    logic       rx_full = 1'b0;
    logic       rx_push;
    logic [7:0] rx_data;
    logic       b0_xfer, b1_xfer;
    logic [7:0] b0_tx, b1_tx, b0_rx, b1_rx;
    logic       busy, striping, underflow, overflow;

    always #10 clk = ~clk;  // 50 MHz

    // source model
    logic [7:0] src [0:31];
    int         src_len = 0;
    int         src_idx = 0;
    assign tx_valid = (src_idx < src_len);
    assign tx_data  = (src_idx < src_len) ? src[src_idx] : 8'h00;

    // bus devices: fixed per-bus transforms
    assign b0_rx = b0_tx ^ 8'h5A;
    assign b1_rx = b1_tx ^ 8'hA5;

    snoop_stripe_top u0 (
        .clk(clk), .rst_n(rst_n), .flush_start(flush_start), .cs_idle(cs_idle),
        .two_mem(two_mem), .sep_bus(sep_bus), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .b0_xfer(b0_xfer), .b0_tx(b0_tx), .b0_rx(b0_rx),
        .b1_xfer(b1_xfer), .b1_tx(b1_tx), .b1_rx(b1_rx),
        .busy(busy), .striping(striping), .underflow(underflow), .overflow(overflow)
    );

    int total = 0;
    int fails = 0;

    // observed and expected logs
    logic [7:0] l0 [0:63];
    logic [7:0] l1 [0:63];
    logic [7:0] lr [0:63];
    logic [7:0] e0 [0:63];
    logic [7:0] e1 [0:63];
    logic [7:0] er [0:63];
    int n0, n1, nr, m0, m1, mr, nund, novr;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input int len, input logic [7:0] first, input logic [7:0] base);
        src[0] = first;
        for (int i = 1; i < 32; i++) src[i] = base + 8'(i);
        src_len = len;
        src_idx = 0;
    endtask

    task automatic flush(input bit full);
        n0 = 0; n1 = 0; nr = 0; nund = 0; novr = 0;
        @(negedge clk);
        rx_full = full;
        flush_start = 1'b1;
        @(negedge clk);
        flush_start = 1'b0;
        for (int k = 0; k < 200; k++) begin
            logic pop;
            if (!busy) break;
            if (b0_xfer) begin l0[n0] = b0_tx; n0++; end
            if (b1_xfer) begin l1[n1] = b1_tx; n1++; end
            if (rx_push) begin lr[nr] = rx_data; nr++; end
            if (underflow) nund++;
            if (overflow) novr++;
            pop = tx_pop;
            @(posedge clk);
            #1;
            if (pop) src_idx++;
            @(negedge clk);
        end
        rx_full = 1'b0;
    endtask

    task automatic cs_pulse();
        @(negedge clk);
        cs_idle = 1'b1;
        @(negedge clk);
        cs_idle = 1'b0;
    endtask

    // expected: first ncopy bytes copied, rest striped (dual) or on bus 0
    task automatic build_exp(input int ncopy, input bit dual, input bit full);
        bit lane = 1'b0;
        m0 = 0; m1 = 0; mr = 0;
        for (int i = 0; i < src_len; i++) begin
            if (i < ncopy || !dual) begin
                e0[m0] = src[i]; m0++;
                if (dual) begin e1[m1] = src[i]; m1++; end
                if (!full) begin er[mr] = src[i] ^ 8'h5A; mr++; end
            end else if (!lane) begin
                e0[m0] = src[i]; m0++;
                if (!full) begin er[mr] = src[i] ^ 8'h5A; mr++; end
                lane = 1'b1;
            end else begin
                e1[m1] = src[i]; m1++;
                if (!full) begin er[mr] = src[i] ^ 8'hA5; mr++; end
                lane = 1'b0;
            end
        end
    endtask

    task automatic compare(input string req);
        int bad0 = 0, bad1 = 0, badr = 0;
        chk(req, "bus0 count", n0, m0);
        chk(req, "bus1 count", n1, m1);
        chk(req, "rx count", nr, mr);
        for (int i = 0; i < m0 && i < n0; i++) if (l0[i] != e0[i]) bad0++;
        for (int i = 0; i < m1 && i < n1; i++) if (l1[i] != e1[i]) bad1++;
        for (int i = 0; i < mr && i < nr; i++) if (lr[i] != er[i]) badr++;
        chk(req, "bus0 byte mismatches", bad0, 0);
        chk(req, "bus1 byte mismatches", bad1, 0);
        chk(req, "rx byte mismatches", badr, 0);
        chk(req, "underflow pulses", nund, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11", "busy after reset", int'(busy), 0);
        chk("R11", "striping after reset", int'(striping), 0);
        chk("R11", "tx_pop after reset", int'(tx_pop), 0);
    endtask

    task automatic t_long_read();
        // R3 R5 R6: EB, 6 copied, 4 striped
        cs_pulse();
        load(11, 8'hEB, 8'h20);
        flush(1'b0);
        build_exp(7, 1'b1, 1'b0);
        compare("R3");
        chk("R6", "striping after long read", int'(striping), 1);
    endtask

    task automatic t_short_read(input logic [7:0] op);
        // R2: 4 copied after opcode
        cs_pulse();
        load(9, op, 8'h40);
        flush(1'b0);
        build_exp(5, 1'b1, 1'b0);
        compare("R2");
    endtask

    task automatic t_persist();
        // R10: no cs_idle, striping continues from first byte
        chk("R10", "striping held", int'(striping), 1);
        load(4, 8'h90, 8'h90);
        flush(1'b0);
        build_exp(0, 1'b1, 1'b0);
        compare("R10");
    endtask

    task automatic t_cs_return();
        // R1 R4: cs_idle clears striping, opcode 03 disables striping
        cs_pulse();
        chk("R1", "striping after cs_idle", int'(striping), 0);
        load(10, 8'h03, 8'h60);
        flush(1'b0);
        build_exp(10, 1'b1, 1'b0);
        compare("R4");
        load(5, 8'hEB, 8'h70);
        flush(1'b0);
        build_exp(5, 1'b1, 1'b0);
        compare("R4");
        chk("R4", "striping after plain opcode", int'(striping), 0);
    endtask

    task automatic t_single(input bit tm, input bit sb);
        // R9: one bus unless both bits set
        cs_pulse();
        two_mem = tm;
        sep_bus = sb;
        load(12, 8'hEB, 8'hB0);
        flush(1'b0);
        build_exp(12, 1'b0, 1'b0);
        compare("R9");
        two_mem = 1'b1;
        sep_bus = 1'b1;
    endtask

    task automatic t_overflow();
        // R8: sink full, transfers go on, nothing pushed
        cs_pulse();
        load(4, 8'h03, 8'h10);
        flush(1'b1);
        build_exp(4, 1'b1, 1'b1);
        compare("R8");
        chk("R8", "overflow pulses", novr, 4);
    endtask

    task automatic t_underflow();
        // R7: empty source, then odd stripe end and lane restart
        cs_pulse();
        load(0, 8'h00, 8'h00);
        flush(1'b0);
        chk("R7", "underflow on empty", nund, 1);
        chk("R7", "no transfer on empty", n0 + n1, 0);
        chk("R7", "busy after underflow", int'(busy), 0);
        load(10, 8'hEB, 8'hC0);
        flush(1'b0);
        build_exp(7, 1'b1, 1'b0);
        compare("R7");
        load(2, 8'hA0, 8'hA0);
        flush(1'b0);
        build_exp(0, 1'b1, 1'b0);
        compare("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_long_read();
        t_short_read(8'h0B);
        t_short_read(8'h6B);
        t_short_read(8'hBB);
        t_persist();
        t_cs_return();
        t_single(1'b0, 1'b1);
        t_single(1'b1, 1'b0);
        t_overflow();
        t_underflow();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule